// File: doc/BRIEF.md
# Receive Character Queue with Trigger Threshold and Idle Timeout

This block sits between a serial receiver and the CPU side of a UART. Each completed character arrives from the deserializer as a byte plus three line-condition flags (parity error, framing error, break). The block holds these in a 16-entry first-in first-out store. The CPU pops the oldest entry with a read strobe, and the head entry is always visible on the outputs.

The block produces four conditions for the interrupt logic, which sits outside it. The first is data-ready. The second is a threshold flag, set when occupancy reaches a selectable level. The third is an idle-timeout flag, set when characters sit unattended for four character times. The fourth is a sticky error summary, which reports that some entry still held, or not yet acknowledged, carries a line-condition flag. An overrun flag records characters that were dropped because the store was full.

A control write enables or disables queue mode, flushes the store, and selects the threshold. With queue mode off, the block acts as a single holding register.

Top module: `uart_rxq`

## Requirements
- R1: After reset, queue mode is off, the store is empty, and data_ready_o, trig_hit_o, timeout_o, err_sum_o and overrun_o are all 0.
- R2: Entries leave in the order they were written. The head outputs carry the byte and the three flags of the oldest entry. data_ready_o is 1 whenever at least one entry is held.
- R3: In queue mode, trig_hit_o is 1 exactly when occupancy is at least the selected level. ctl_trig_i value 0 selects 1 entry, 1 selects 4, 2 selects 8 and 3 selects 14. The flag drops as soon as occupancy falls below the level.
- R4: A write while the store is at capacity, with no read in the same cycle, is dropped. Stored entries are left unchanged and overrun_o is set. overrun_o stays set until a line-status read.
- R5: In queue mode, timeout_o is 1 when at least one entry is held and four char_tick_i pulses have arrived with no write or read accepted since. Any accepted write or read clears the count, so a read removes the flag.
- R6: err_sum_o becomes 1 once an entry carrying a parity, framing or break flag is stored. A line-status read clears it only when no flagged entry remains in the store. Without that read, it stays 1 after the flagged entries have been read out.
- R7: A control write with ctl_en_i=1 and ctl_rxclr_i=1 empties the store, clears the timeout count and clears err_sum_o.
- R8: A control write with ctl_en_i=0 ignores ctl_rxclr_i and ctl_trig_i. A control write that changes the enable state flushes the store.
- R9: With queue mode off, capacity is one entry, trig_hit_o equals data_ready_o, and err_sum_o and timeout_o are 0.
- R10: A CPU read while the store is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | Write strobe for a received character |
| wr_data_i | input | 8 | Received byte |
| wr_perr_i | input | 1 | Parity error flag of the received character |
| wr_ferr_i | input | 1 | Framing error flag of the received character |
| wr_brk_i | input | 1 | Break flag of the received character |
| rd_i | input | 1 | CPU read strobe; pops the head entry |
| lsr_rd_i | input | 1 | Line-status read strobe |
| ctl_wr_i | input | 1 | Control write strobe |
| ctl_en_i | input | 1 | Queue mode enable in the control write |
| ctl_rxclr_i | input | 1 | Flush request in the control write |
| ctl_trig_i | input | 2 | Threshold select in the control write |
| char_tick_i | input | 1 | One pulse per character time |
| head_data_o | output | 8 | Byte of the oldest entry |
| head_perr_o | output | 1 | Parity error flag of the oldest entry |
| head_ferr_o | output | 1 | Framing error flag of the oldest entry |
| head_brk_o | output | 1 | Break flag of the oldest entry |
| data_ready_o | output | 1 | At least one entry held |
| err_sum_o | output | 1 | Sticky line-condition summary |
| trig_hit_o | output | 1 | Occupancy at or above the threshold |
| timeout_o | output | 1 | Idle timeout |
| overrun_o | output | 1 | A character was dropped |

## Verification
The bench uses the default values: a depth of 16 and a timeout of four character times. This lets it fill the store to the 14-entry threshold and to capacity, so the top threshold and the overrun drop are both exercised on the real depth. A short timeout keeps the expiry edge within a few ticks. Random phases move between filling and draining, with occasional flushes, mode changes and line-status reads. These phases push the error counter and pointer wrap through many combinations.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

    localparam int RXQ_DATA_W = 8;

    typedef struct packed {
        logic                  brk;
        logic                  ferr;
        logic                  perr;
        logic [RXQ_DATA_W-1:0] data;
    } rxq_entry_t;

    // Threshold in entries; with queue mode off a single entry is the threshold.
    function automatic int unsigned rxq_level(input logic en, input logic [1:0] sel);
        if (!en) return 1;
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we_i,
    input  logic [PTR_W-1:0] waddr_i,
    input  rxq_entry_t       wdata_i,
    input  logic [PTR_W-1:0] raddr_i,
    output rxq_entry_t       rdata_o
);

    rxq_entry_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/rxq_timer.sv
module rxq_timer #(
    parameter int CHARS = 4,
    localparam int TC_W = $clog2(CHARS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic tick_i,
    output logic expired_o
);

    logic [TC_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)                                cnt_d = '0;
        else if (tick_i && cnt_q < TC_W'(CHARS))  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == TC_W'(CHARS));

    p_timer_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TC_W'(CHARS));

    p_timer_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && tick_i && !expired_o) |=> (cnt_q == $past(cnt_q) + 1'b1));

    p_timer_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !expired_o);

endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int TO_CHARS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_valid_i,
    input  logic [RXQ_DATA_W-1:0] wr_data_i,
    input  logic                  wr_perr_i,
    input  logic                  wr_ferr_i,
    input  logic                  wr_brk_i,
    input  logic                  rd_i,
    input  logic                  lsr_rd_i,
    input  logic                  ctl_wr_i,
    input  logic                  ctl_en_i,
    input  logic                  ctl_rxclr_i,
    input  logic [1:0]            ctl_trig_i,
    input  logic                  char_tick_i,
    output logic [RXQ_DATA_W-1:0] head_data_o,
    output logic                  head_perr_o,
    output logic                  head_ferr_o,
    output logic                  head_brk_o,
    output logic                  data_ready_o,
    output logic                  err_sum_o,
    output logic                  trig_hit_o,
    output logic                  timeout_o,
    output logic                  overrun_o
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] ecnt;
        logic             en;
        logic [1:0]       trig;
        logic             esum;
        logic             ovr;
    } rxq_state_t;

    rxq_state_t st_d, st_q;
    rxq_entry_t head, wentry;
    logic       flush, push, pop, ovr_set, tmr_clr, tmr_exp;
    logic [CNT_W-1:0] cap;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign wentry = '{brk: wr_brk_i, ferr: wr_ferr_i, perr: wr_perr_i, data: wr_data_i};

    always_comb begin
        st_d  = st_q;
        flush = 1'b0;
        if (ctl_wr_i) begin
            if (ctl_en_i != st_q.en) flush = 1'b1;
            st_d.en = ctl_en_i;
            if (ctl_en_i) begin
                st_d.trig = ctl_trig_i;
                if (ctl_rxclr_i) flush = 1'b1;
            end
        end

        cap     = st_q.en ? CNT_W'(DEPTH) : CNT_W'(1);
        pop     = !flush && rd_i && (st_q.cnt != '0);
        push    = !flush && wr_valid_i && ((st_q.cnt < cap) || pop);
        ovr_set = !flush && wr_valid_i && !push;

        if (flush) begin
            st_d.wp   = '0;
            st_d.rp   = '0;
            st_d.cnt  = '0;
            st_d.ecnt = '0;
            st_d.esum = 1'b0;
        end else begin
            if (push) st_d.wp = ptr_next(st_q.wp);
            if (pop)  st_d.rp = ptr_next(st_q.rp);
            st_d.cnt  = st_q.cnt + CNT_W'(push) - CNT_W'(pop);
            st_d.ecnt = st_q.ecnt
                      + CNT_W'(push && (wr_perr_i || wr_ferr_i || wr_brk_i))
                      - CNT_W'(pop && (head.perr || head.ferr || head.brk));
            st_d.esum = st_q.en && ((st_d.ecnt != '0) || (st_q.esum && !lsr_rd_i));
        end
        st_d.ovr = (st_q.ovr && !lsr_rd_i) || ovr_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .we_i    (push),
        .waddr_i (st_q.wp),
        .wdata_i (wentry),
        .raddr_i (st_q.rp),
        .rdata_o (head)
    );

    assign tmr_clr = push || pop || flush || (st_q.cnt == '0);

    rxq_timer #(.CHARS(TO_CHARS)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (tmr_clr),
        .tick_i    (char_tick_i),
        .expired_o (tmr_exp)
    );

    assign head_data_o  = head.data;
    assign head_perr_o  = head.perr;
    assign head_ferr_o  = head.ferr;
    assign head_brk_o   = head.brk;
    assign data_ready_o = (st_q.cnt != '0);
    assign trig_hit_o   = (32'(st_q.cnt) >= rxq_level(st_q.en, st_q.trig));
    assign timeout_o    = st_q.en && tmr_exp && (st_q.cnt != '0);
    assign err_sum_o    = st_q.esum;
    assign overrun_o    = st_q.ovr;

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));

    p_full_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_i && !rd_i && !ctl_wr_i && st_q.cnt == CNT_W'(DEPTH))
        |=> (overrun_o && $stable(st_q.cnt) && $stable(st_q.wp)));

    p_err_below_cnt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ecnt <= st_q.cnt);

    p_timeout_needs_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> data_ready_o);

    p_trig_needs_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        trig_hit_o |-> data_ready_o);

    p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_i && ctl_en_i && ctl_rxclr_i) |=> (!data_ready_o && !err_sum_o));

    p_single_no_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.en |-> (!err_sum_o && !timeout_o && st_q.cnt <= CNT_W'(1)));

    p_empty_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_ready_o && rd_i && !wr_valid_i && !ctl_wr_i) |=> !data_ready_o);

endmodule

// File: tb/uart_rxq_tb.sv
module uart_rxq_tb;

    localparam int DEPTH = 16;
    localparam int TO    = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 0, wr_perr = 0, wr_ferr = 0, wr_brk = 0;
    logic [7:0] wr_data = 0;
    logic       rd = 0, lsr_rd = 0, ctl_wr = 0, ctl_en = 0, ctl_rxclr = 0, tick = 0;
    logic [1:0] ctl_trig = 0;
    logic [7:0] head_data;
    logic       head_perr, head_ferr, head_brk;
    logic       data_ready, err_sum, trig_hit, timeout, overrun;

    always #4 clk = ~clk;

    uart_rxq #(.DEPTH(DEPTH), .TO_CHARS(TO)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .wr_valid_i(wr_valid), .wr_data_i(wr_data), .wr_perr_i(wr_perr),
        .wr_ferr_i(wr_ferr), .wr_brk_i(wr_brk), .rd_i(rd), .lsr_rd_i(lsr_rd),
        .ctl_wr_i(ctl_wr), .ctl_en_i(ctl_en), .ctl_rxclr_i(ctl_rxclr),
        .ctl_trig_i(ctl_trig), .char_tick_i(tick),
        .head_data_o(head_data), .head_perr_o(head_perr), .head_ferr_o(head_ferr),
        .head_brk_o(head_brk), .data_ready_o(data_ready), .err_sum_o(err_sum),
        .trig_hit_o(trig_hit), .timeout_o(timeout), .overrun_o(overrun)
    );

    int checks = 0;
    int errors = 0;

    // Reference state, built from the requirements: entry = {brk, ferr, perr, data}
    logic [10:0] mq[$];
    bit       m_en = 0, m_ovr = 0, m_es = 0;
    bit [1:0] m_trig = 0;
    int       m_tc = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int level();
        if (!m_en) return 1;
        case (m_trig)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 14;
        endcase
    endfunction

    task automatic model_step();
        bit fl = 0;
        bit pop, push;
        int cap, nflag;
        int sz = mq.size();
        bit nen = m_en;
        if (ctl_wr) begin
            if (ctl_en != m_en) fl = 1;
            nen = ctl_en;
            if (ctl_en) begin
                m_trig = ctl_trig;
                if (ctl_rxclr) fl = 1;
            end
        end
        cap  = m_en ? DEPTH : 1;
        pop  = !fl && rd && sz > 0;
        push = !fl && wr_valid && (sz < cap || pop);
        m_ovr = (m_ovr && !lsr_rd) || (!fl && wr_valid && !push);
        if (fl) begin
            mq.delete();
            m_tc = 0;
            m_es = 0;
        end else begin
            if (pop)  void'(mq.pop_front());
            if (push) mq.push_back({wr_brk, wr_ferr, wr_perr, wr_data});
            if (push || pop || sz == 0) m_tc = 0;
            else if (tick && m_tc < TO) m_tc++;
            nflag = 0;
            foreach (mq[i]) if (mq[i][10:8] != 0) nflag++;
            m_es = m_en && (nflag != 0 || (m_es && !lsr_rd));
        end
        m_en = nen;
    endtask

    task automatic check_all();
        chk("R2", "data_ready", data_ready, mq.size() > 0);
        if (mq.size() > 0)
            chk("R2", "head entry", {head_brk, head_ferr, head_perr, head_data}, mq[0]);
        chk("R3", "trig_hit", trig_hit, mq.size() >= level());
        chk("R5", "timeout", timeout, m_en && m_tc == TO && mq.size() > 0);
        chk("R6", "err_sum", err_sum, m_es);
        chk("R4", "overrun", overrun, m_ovr);
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_all();
        wr_valid = 0; wr_perr = 0; wr_ferr = 0; wr_brk = 0;
        rd = 0; lsr_rd = 0; ctl_wr = 0; ctl_rxclr = 0; tick = 0;
    endtask

    task automatic put(input logic [7:0] d, input logic [2:0] f);
        wr_valid = 1; wr_data = d; {wr_brk, wr_ferr, wr_perr} = f;
        cyc();
    endtask

    task automatic ctl(input bit en, input bit clr, input logic [1:0] trg);
        ctl_wr = 1; ctl_en = en; ctl_rxclr = clr; ctl_trig = trg;
        cyc();
    endtask

    task automatic rand_phase(input int n, input int pw, input int pr);
        for (int i = 0; i < n; i++) begin
            wr_valid = ($urandom % 100) < pw;
            wr_data  = 8'($urandom);
            wr_perr  = ($urandom % 16) == 0;
            wr_ferr  = ($urandom % 16) == 0;
            wr_brk   = ($urandom % 24) == 0;
            rd       = ($urandom % 100) < pr;
            lsr_rd   = ($urandom % 20) == 0;
            tick     = ($urandom % 3) == 0;
            if (($urandom % 150) == 0) begin
                ctl_wr    = 1;
                ctl_en    = ($urandom % 8) != 0;
                ctl_rxclr = ($urandom % 3) == 0;
                ctl_trig  = 2'($urandom);
            end
            cyc();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1C0FFEE5));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "data_ready", data_ready, 0);
        chk("R1", "trig_hit", trig_hit, 0);
        chk("R1", "timeout", timeout, 0);
        chk("R1", "err_sum", err_sum, 0);
        chk("R1", "overrun", overrun, 0);

        // R10: read on empty
        rd = 1; cyc();
        chk("R10", "data_ready after empty read", data_ready, 0);

        // R3: highest threshold
        ctl(1, 0, 2'd3);
        for (int i = 0; i < 13; i++) put(8'(i + 1), 3'b000);
        chk("R3", "13 entries at level 14", trig_hit, 0);
        put(8'hAA, 3'b000);
        chk("R3", "14 entries at level 14", trig_hit, 1);
        rd = 1; cyc();
        chk("R3", "dropped below level", trig_hit, 0);
        chk("R2", "head after one pop", head_data, 2);

        // R4: overrun at capacity
        for (int i = 0; i < 3; i++) put(8'(8'h40 + i), 3'b000);
        put(8'hEE, 3'b000);
        chk("R4", "overrun set", overrun, 1);
        chk("R4", "head kept", head_data, 2);
        lsr_rd = 1; cyc();
        chk("R4", "overrun cleared by status read", overrun, 0);

        // R7: flush
        ctl(1, 1, 2'd0);
        chk("R7", "flushed", data_ready, 0);

        // R5: timeout edge
        put(8'h55, 3'b000);
        for (int i = 0; i < 3; i++) begin tick = 1; cyc(); end
        chk("R5", "three ticks", timeout, 0);
        tick = 1; cyc();
        chk("R5", "four ticks", timeout, 1);
        rd = 1; cyc();
        chk("R5", "read clears", timeout, 0);
        put(8'h56, 3'b000);
        for (int i = 0; i < 4; i++) begin tick = 1; cyc(); end
        put(8'h57, 3'b000);
        chk("R5", "write clears", timeout, 0);

        // R6: error summary
        ctl(1, 1, 2'd0);
        put(8'h01, 3'b001);
        put(8'h02, 3'b000);
        chk("R6", "flag stored", err_sum, 1);
        rd = 1; cyc();
        chk("R6", "sticky after read-out", err_sum, 1);
        lsr_rd = 1; cyc();
        chk("R6", "cleared, none left", err_sum, 0);
        put(8'h03, 3'b100);
        put(8'h04, 3'b010);
        lsr_rd = 1; cyc();
        chk("R6", "held, flagged remain", err_sum, 1);

        // R8 / R9: single-register mode
        ctl(0, 0, 2'd0);
        chk("R8", "enable change flushes", data_ready, 0);
        put(8'h77, 3'b001);
        chk("R9", "no summary", err_sum, 0);
        chk("R9", "trig equals ready", trig_hit, 1);
        ctl(0, 1, 2'd3);
        chk("R8", "clear ignored when disabled", data_ready, 1);
        chk("R8", "entry kept", head_data, 8'h77);
        put(8'h78, 3'b000);
        chk("R9", "capacity one", overrun, 1);
        ctl(1, 0, 2'd1);
        chk("R8", "enable flushes", data_ready, 0);

        rand_phase(3000, 70, 30);
        rand_phase(3000, 40, 45);
        rand_phase(2000, 20, 70);
        rand_phase(3000, 55, 50);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule